// File: doc/BRIEF.md
# Task-Switch Segment Descriptor Checker

This block judges one segment selector, together with the descriptor fields fetched for it, while a task switch reloads the segment state of the incoming task. For each selector, the caller names the slot being loaded: data, extra, stack, code or local-table. It also supplies the raw 16-bit selector, a flag that says whether the descriptor fetch succeeded, the decoded descriptor fields (present, code/data versus system, 4-bit type, DPL) and the requested privilege level of the new code selector. The checker applies the rules for that slot in a fixed priority. It returns an accept flag, a flag that says whether the descriptor cache may be filled, one of three fault classes, and the error code for the fault.

The judgement itself is combinational. A small two-state machine registers the result one cycle after the input strobe. The machine is in `ST_IDLE` when no result is pending and in `ST_REPORT` during the cycle in which a result is presented. The transition `GO_REPORT` is taken from either state on a strobe. The transition `GO_IDLE` is taken from `ST_REPORT` when no strobe follows. Strobes may arrive back to back. The descriptor-table lookup is done elsewhere and is not part of this block.

Top module: `tsk_desc_checker`

## Requirements
- R1: The result for a strobe on `chk_valid` sampled at clock edge N appears on the outputs after edge N, with `res_valid` high for exactly that one cycle. Without a strobe `res_valid` is low, and reset clears `res_valid`, `res_accept`, `res_cache_ok`, `res_fault` and `res_err`.
- R2: On a fault, `res_err` equals `chk_sel` with bits 1:0 forced to zero. On acceptance, `res_err` is zero. Fault codes are 0 none, 1 invalid-task, 2 not-present and 3 stack.
- R3: A null selector (bits 15:2 all zero) in the data (slot 0), extra (slot 1) or local-table (slot 4) slot is accepted with `res_cache_ok` low, whatever the fetch flag and descriptor say.
- R4: A null selector in the stack (slot 2) or code (slot 3) slot gives an invalid-task fault.
- R5: A non-null selector whose fetch failed gives an invalid-task fault in every slot. This check outranks all descriptor checks.
- R6: In the data and extra slots, a system descriptor (`dsc_code_data`=0) or an execute-only code segment gives an invalid-task fault. In the type field, bit 3 is 1 for code, bit 2 marks a conforming code segment, and bit 1 marks readable code or writable data.
- R7: In the data and extra slots, for data or non-conforming code, a selector RPL or `cs_rpl` greater than the DPL gives an invalid-task fault. Conforming code is exempt from this check.
- R8: In the data and extra slots, a descriptor that passes the type and privilege checks but is not present gives a not-present fault. Privilege is checked before presence.
- R9: In the stack slot, anything other than a present-or-absent writable data segment gives an invalid-task fault. A writable data segment that is not present gives a stack fault, and this is checked before the DPL matches.
- R10: In the stack slot, a DPL that differs from `cs_rpl` or from the selector RPL gives an invalid-task fault. Otherwise the descriptor is accepted with `res_cache_ok` high.
- R11: In the code slot, a system or data descriptor gives an invalid-task fault. Non-conforming code requires DPL equal to RPL, and conforming code requires DPL not above RPL. A violation of either gives an invalid-task fault.
- R12: In the code slot, a code segment that passes the privilege rule but is not present gives a not-present fault.
- R13: In the local-table slot, a table-indicator bit (bit 2) of 1 gives an invalid-task fault, as does a descriptor that is not a system descriptor of type 2. A proper type that is not present also gives an invalid-task fault.
- R14: Slot codes 5, 6 and 7 give an invalid-task fault for every selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Strobe: judge the present inputs |
| chk_slot | input | 3 | Slot being loaded (0 data, 1 extra, 2 stack, 3 code, 4 local-table) |
| chk_sel | input | 16 | Raw selector |
| fetch_ok | input | 1 | Descriptor fetch succeeded |
| dsc_present | input | 1 | Descriptor present bit |
| dsc_code_data | input | 1 | 1 = code/data segment, 0 = system descriptor |
| dsc_type | input | 4 | Descriptor type field |
| dsc_dpl | input | 2 | Descriptor privilege level |
| cs_rpl | input | 2 | RPL of the new code selector |
| res_valid | output | 1 | Result valid, one cycle per strobe |
| res_accept | output | 1 | Selector accepted |
| res_cache_ok | output | 1 | Descriptor cache may be filled |
| res_fault | output | 2 | Fault class |
| res_err | output | 16 | Error code |

## Verification
The bench aims at the priority seams between checks. A stack segment that is both absent and privilege-mismatched must produce a stack fault; a design that checks privilege first would report invalid-task. A data selector that is both over-privileged and absent must report invalid-task; a swapped order would wrongly report not-present. It drives null selectors with nonzero RPL bits and a failed fetch, which a design that tests all 16 bits, or that tests the fetch flag first, would reject. It also covers conforming readable code in the data slot, which is exempt from the privilege check; a table-indicator selector with index zero in the local-table slot, which is not null; and back-to-back strobes, where a design that holds a stale result would shift every comparison by one.

// File: rtl/tskchk_pkg.sv
package tskchk_pkg;

    typedef enum logic [2:0] {
        SLOT_DATA  = 3'd0,
        SLOT_EXTRA = 3'd1,
        SLOT_STACK = 3'd2,
        SLOT_CODE  = 3'd3,
        SLOT_LTAB  = 3'd4
    } slot_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_TASK   = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_STACK  = 2'd3
    } fault_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } phase_e;

    localparam logic [3:0] LTAB_TYPE = 4'h2;
    localparam int         TYP_CODE  = 3;
    localparam int         TYP_CONF  = 2;
    localparam int         TYP_RW    = 1;

    typedef struct packed {
        logic       present;
        logic       code_data;
        logic [3:0] typ;
        logic [1:0] dpl;
    } desc_t;

    typedef struct packed {
        logic   accept;
        logic   cache_ok;
        fault_e fault;
    } verdict_t;

endpackage

// File: rtl/tsk_sel_decode.sv
module tsk_sel_decode #(
    parameter int SEL_W = 16,
    parameter int PL_W  = 2
) (
    input  logic [SEL_W-1:0] sel,
    output logic [PL_W-1:0]  rpl,
    output logic             table_ind,
    output logic             is_null,
    output logic [SEL_W-1:0] err_code
);
    localparam int IDX_LO = PL_W + 1;

    always_comb begin
        rpl       = sel[PL_W-1:0];
        table_ind = sel[PL_W];
        is_null   = (sel[SEL_W-1:PL_W] == '0);
        err_code  = {sel[SEL_W-1:PL_W], {PL_W{1'b0}}};
    end

    // Index bits only matter together with the indicator bit for nullness.
    logic idx_zero;
    assign idx_zero = (sel[SEL_W-1:IDX_LO] == '0);

    always_comb begin
        assert_null_split_R3: assert (is_null == (idx_zero && !table_ind));
    end
endmodule

// File: rtl/tsk_rule_eval.sv
module tsk_rule_eval
    import tskchk_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic [2:0]      slot,
    input  logic            is_null,
    input  logic            table_ind,
    input  logic [PL_W-1:0] rpl,
    input  logic [PL_W-1:0] cs_rpl,
    input  logic            fetch_ok,
    input  desc_t           desc,
    output verdict_t        verdict
);
    logic is_code, is_conf, rw_bit;
    logic dx_type_bad, dx_priv_bad;
    logic stk_type_bad, stk_priv_bad;
    logic cs_type_bad, cs_priv_bad;
    logic lt_type_bad;

    always_comb begin
        is_code      = desc.typ[TYP_CODE];
        is_conf      = desc.typ[TYP_CONF];
        rw_bit       = desc.typ[TYP_RW];

        dx_type_bad  = !desc.code_data || (is_code && !rw_bit);
        dx_priv_bad  = (!is_code || !is_conf) &&
                       ((rpl > desc.dpl) || (cs_rpl > desc.dpl));

        stk_type_bad = !desc.code_data || is_code || !rw_bit;
        stk_priv_bad = (desc.dpl != cs_rpl) || (desc.dpl != rpl);

        cs_type_bad  = !desc.code_data || !is_code;
        cs_priv_bad  = is_conf ? (desc.dpl > rpl) : (desc.dpl != rpl);

        lt_type_bad  = desc.code_data || (desc.typ != LTAB_TYPE);
    end

    function automatic verdict_t pass_v(input logic fill);
        verdict_t v;
        v.accept   = 1'b1;
        v.cache_ok = fill;
        v.fault    = FLT_NONE;
        return v;
    endfunction

    function automatic verdict_t fail_v(input fault_e f);
        verdict_t v;
        v.accept   = 1'b0;
        v.cache_ok = 1'b0;
        v.fault    = f;
        return v;
    endfunction

    always_comb begin
        verdict = fail_v(FLT_TASK);
        unique case (slot)
            SLOT_DATA, SLOT_EXTRA: begin
                if (is_null)             verdict = pass_v(1'b0);
                else if (!fetch_ok)      verdict = fail_v(FLT_TASK);
                else if (dx_type_bad)    verdict = fail_v(FLT_TASK);
                else if (dx_priv_bad)    verdict = fail_v(FLT_TASK);
                else if (!desc.present)  verdict = fail_v(FLT_ABSENT);
                else                     verdict = pass_v(1'b1);
            end
            SLOT_STACK: begin
                if (is_null)             verdict = fail_v(FLT_TASK);
                else if (!fetch_ok)      verdict = fail_v(FLT_TASK);
                else if (stk_type_bad)   verdict = fail_v(FLT_TASK);
                else if (!desc.present)  verdict = fail_v(FLT_STACK);
                else if (stk_priv_bad)   verdict = fail_v(FLT_TASK);
                else                     verdict = pass_v(1'b1);
            end
            SLOT_CODE: begin
                if (is_null)             verdict = fail_v(FLT_TASK);
                else if (!fetch_ok)      verdict = fail_v(FLT_TASK);
                else if (cs_type_bad)    verdict = fail_v(FLT_TASK);
                else if (cs_priv_bad)    verdict = fail_v(FLT_TASK);
                else if (!desc.present)  verdict = fail_v(FLT_ABSENT);
                else                     verdict = pass_v(1'b1);
            end
            SLOT_LTAB: begin
                if (table_ind)           verdict = fail_v(FLT_TASK);
                else if (is_null)        verdict = pass_v(1'b0);
                else if (!fetch_ok)      verdict = fail_v(FLT_TASK);
                else if (lt_type_bad)    verdict = fail_v(FLT_TASK);
                else if (!desc.present)  verdict = fail_v(FLT_TASK);
                else                     verdict = pass_v(1'b1);
            end
            default:                     verdict = fail_v(FLT_TASK);
        endcase
    end

    always_comb begin
        assert_ltab_no_absent_R13: assert (!(slot == SLOT_LTAB && verdict.fault == FLT_ABSENT));
        assert_null_code_rejected_R4: assert (!(slot == SLOT_CODE && is_null && verdict.accept));
    end
endmodule

// File: rtl/tsk_desc_checker.sv
module tsk_desc_checker
    import tskchk_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int PL_W   = 2,
    parameter int TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic [2:0]        chk_slot,
    input  logic [SEL_W-1:0]  chk_sel,
    input  logic              fetch_ok,
    input  logic              dsc_present,
    input  logic              dsc_code_data,
    input  logic [TYPE_W-1:0] dsc_type,
    input  logic [PL_W-1:0]   dsc_dpl,
    input  logic [PL_W-1:0]   cs_rpl,
    output logic              res_valid,
    output logic              res_accept,
    output logic              res_cache_ok,
    output logic [1:0]        res_fault,
    output logic [SEL_W-1:0]  res_err
);
    phase_e            state, state_nx;
    logic [PL_W-1:0]   sel_rpl;
    logic              sel_ti, sel_null;
    logic [SEL_W-1:0]  sel_err;
    desc_t             desc;
    verdict_t          verdict;

    assign desc = '{present: dsc_present, code_data: dsc_code_data,
                    typ: dsc_type, dpl: dsc_dpl};

    tsk_sel_decode #(.SEL_W(SEL_W), .PL_W(PL_W)) u_dec (
        .sel       (chk_sel),
        .rpl       (sel_rpl),
        .table_ind (sel_ti),
        .is_null   (sel_null),
        .err_code  (sel_err)
    );

    tsk_rule_eval #(.PL_W(PL_W)) u_rules (
        .slot      (chk_slot),
        .is_null   (sel_null),
        .table_ind (sel_ti),
        .rpl       (sel_rpl),
        .cs_rpl    (cs_rpl),
        .fetch_ok  (fetch_ok),
        .desc      (desc),
        .verdict   (verdict)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (chk_valid)  state_nx = ST_REPORT;
            ST_REPORT: if (!chk_valid) state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_accept   <= 1'b0;
            res_cache_ok <= 1'b0;
            res_fault    <= FLT_NONE;
            res_err      <= '0;
        end else if (chk_valid) begin
            res_accept   <= verdict.accept;
            res_cache_ok <= verdict.cache_ok;
            res_fault    <= verdict.fault;
            res_err      <= verdict.accept ? '0 : sel_err;
        end
    end

    assign res_valid = (state == ST_REPORT);

    assert_strobe_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(chk_valid));
    assert_accept_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept) |-> (res_fault == FLT_NONE && res_err == '0));
    assert_err_low_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_err[PL_W-1:0] == '0));
    assert_stack_fault_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == FLT_STACK) |-> ($past(chk_slot) == SLOT_STACK));
    assert_fault_err_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !verdict.accept) |=> (res_err[SEL_W-1:PL_W] == $past(chk_sel[SEL_W-1:PL_W])));
    assert_cache_needs_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_cache_ok) |-> res_accept);
endmodule

// File: tb/tsk_desc_checker_bench.sv
module tsk_desc_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        chk_valid;
    logic [2:0]  chk_slot;
    logic [15:0] chk_sel;
    logic        fetch_ok, dsc_present, dsc_code_data;
    logic [3:0]  dsc_type;
    logic [1:0]  dsc_dpl, cs_rpl;
    logic        res_valid, res_accept, res_cache_ok;
    logic [1:0]  res_fault;
    logic [15:0] res_err;

    always #5 clk = ~clk;

    tsk_desc_checker u_tsk_desc_checker (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_slot(chk_slot),
        .chk_sel(chk_sel), .fetch_ok(fetch_ok), .dsc_present(dsc_present),
        .dsc_code_data(dsc_code_data), .dsc_type(dsc_type), .dsc_dpl(dsc_dpl),
        .cs_rpl(cs_rpl), .res_valid(res_valid), .res_accept(res_accept),
        .res_cache_ok(res_cache_ok), .res_fault(res_fault), .res_err(res_err)
    );

    typedef struct {
        logic        acc;
        logic        cok;
        logic [1:0]  flt;
        logic [15:0] err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;

    // Fault codes and type values from the requirements
    localparam logic [1:0] F_NO = 2'd0, F_TS = 2'd1, F_NP = 2'd2, F_SS = 2'd3;
    localparam logic [3:0] T_DRO = 4'b0000, T_DRW = 4'b0010, T_CX = 4'b1000,
                           T_CR = 4'b1010, T_CCX = 4'b1100, T_CCR = 4'b1110;

    task automatic drive(input logic [2:0] slot, input logic [15:0] sel,
                         input logic fok, input logic p, input logic s,
                         input logic [3:0] typ, input logic [1:0] dpl,
                         input logic [1:0] csr, input logic acc, input logic cok,
                         input logic [1:0] flt, input string tag);
        exp_t e;
        @(negedge clk);
        chk_valid = 1'b1; chk_slot = slot; chk_sel = sel; fetch_ok = fok;
        dsc_present = p; dsc_code_data = s; dsc_type = typ; dsc_dpl = dpl; cs_rpl = csr;
        e.acc = acc; e.cok = cok; e.flt = flt;
        e.err = acc ? 16'h0000 : (sel & 16'hFFFC);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1 && res_valid === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1: unexpected res_valid actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (res_accept !== e.acc || res_cache_ok !== e.cok ||
                    res_fault !== e.flt || res_err !== e.err) begin
                    errors++;
                    $display("FAIL %s: actual acc=%0b cok=%0b flt=%0d err=%h expected acc=%0b cok=%0b flt=%0d err=%h",
                             e.tag, res_accept, res_cache_ok, res_fault, res_err,
                             e.acc, e.cok, e.flt, e.err);
                end
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; chk_valid = 1'b0; chk_slot = '0; chk_sel = '0; fetch_ok = 1'b0;
        dsc_present = 1'b0; dsc_code_data = 1'b0; dsc_type = '0; dsc_dpl = '0; cs_rpl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_accept !== 1'b0 || res_fault !== 2'd0 || res_err !== 16'h0) begin
            errors++;
            $display("FAIL R1: reset state actual v=%0b a=%0b f=%0d e=%h expected 0", res_valid, res_accept, res_fault, res_err);
        end
        // slot: 0 data 1 extra 2 stack 3 code 4 ltab
        drive(0, 16'h0003, 1, 1, 1, T_DRW, 0, 0, 1, 0, F_NO, "R3 null data rpl3");
        drive(1, 16'h0000, 0, 0, 0, T_CX,  0, 3, 1, 0, F_NO, "R3 null extra bad fetch");
        drive(4, 16'h0000, 1, 1, 0, 4'h9,  0, 0, 1, 0, F_NO, "R3 null ltab");
        drive(2, 16'h0002, 1, 1, 1, T_DRW, 2, 2, 0, 0, F_TS, "R4 null stack");
        drive(3, 16'h0000, 1, 1, 1, T_CR,  0, 0, 0, 0, F_TS, "R4 null code");
        drive(0, 16'h0013, 0, 1, 1, T_DRW, 3, 0, 0, 0, F_TS, "R5 data fetch fail");
        drive(2, 16'h002B, 0, 0, 1, T_DRW, 3, 3, 0, 0, F_TS, "R5 stack fetch fail outranks present");
        drive(0, 16'h0020, 1, 1, 1, T_CX,  3, 0, 0, 0, F_TS, "R6 exec-only code in data");
        drive(1, 16'h0020, 1, 1, 0, T_DRW, 3, 0, 0, 0, F_TS, "R6 system desc in extra");
        drive(0, 16'h0023, 1, 1, 1, T_DRW, 2, 0, 0, 0, F_TS, "R7 rpl above dpl");
        drive(1, 16'h0020, 1, 1, 1, T_DRO, 2, 3, 0, 0, F_TS, "R7 cs_rpl above dpl");
        drive(0, 16'h0023, 1, 1, 1, T_CCR, 0, 3, 1, 1, F_NO, "R7 conforming exempt");
        drive(0, 16'h0023, 1, 1, 1, T_CR,  3, 3, 1, 1, F_NO, "R7 readable code ok");
        drive(0, 16'h0031, 1, 0, 1, T_DRW, 0, 0, 0, 0, F_TS, "R8 priv before present");
        drive(1, 16'h0030, 1, 0, 1, T_DRW, 3, 0, 0, 0, F_NP, "R8 extra absent");
        drive(2, 16'h0040, 1, 1, 1, T_CR,  0, 0, 0, 0, F_TS, "R9 code in stack");
        drive(2, 16'h0040, 1, 1, 1, T_DRO, 0, 0, 0, 0, F_TS, "R9 read-only stack");
        drive(2, 16'h0040, 1, 0, 1, T_DRW, 1, 0, 0, 0, F_SS, "R9 absent before dpl");
        drive(2, 16'h0040, 1, 1, 1, T_DRW, 0, 0, 1, 1, F_NO, "R10 stack ok");
        drive(2, 16'h0041, 1, 1, 1, T_DRW, 1, 0, 0, 0, F_TS, "R10 cs_rpl mismatch");
        drive(2, 16'h0042, 1, 1, 1, T_DRW, 1, 1, 0, 0, F_TS, "R10 rpl mismatch");
        drive(3, 16'h0050, 1, 1, 1, T_DRW, 0, 0, 0, 0, F_TS, "R11 data in code");
        drive(3, 16'h0052, 1, 1, 1, T_CX,  1, 0, 0, 0, F_TS, "R11 nonconf dpl!=rpl");
        drive(3, 16'h0052, 1, 1, 1, T_CCX, 1, 0, 1, 1, F_NO, "R11 conforming dpl<rpl ok");
        drive(3, 16'h0051, 1, 1, 1, T_CCX, 2, 0, 0, 0, F_TS, "R11 conforming dpl>rpl");
        drive(3, 16'h0052, 1, 0, 1, T_CX,  2, 0, 0, 0, F_NP, "R12 code absent");
        drive(3, 16'h0051, 1, 0, 1, T_CX,  2, 0, 0, 0, F_TS, "R12 priv before present");
        drive(4, 16'h0004, 1, 1, 0, 4'h2,  0, 0, 0, 0, F_TS, "R13 table indicator");
        drive(4, 16'h0060, 1, 1, 0, 4'h2,  0, 0, 1, 1, F_NO, "R13 ltab ok");
        drive(4, 16'h0060, 1, 1, 0, 4'h9,  0, 0, 0, 0, F_TS, "R13 wrong type");
        drive(4, 16'h0060, 1, 0, 0, 4'h2,  0, 0, 0, 0, F_TS, "R13 ltab absent");
        drive(5, 16'h0070, 1, 1, 1, T_DRW, 3, 0, 0, 0, F_TS, "R14 slot 5");
        drive(7, 16'h0000, 1, 1, 1, T_DRW, 3, 0, 0, 0, F_TS, "R14 slot 7 null");
        @(negedge clk);
        chk_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1: idle actual valid=%0b pending=%0d expected valid=0 pending=0", res_valid, exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule